// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Signed Overflow Trap

This block is the combinational execute-stage ALU of a 32-bit load/store processor. Each evaluation takes two register operands, a 16-bit instruction immediate, a 5-bit instruction shift count and a 5-bit operation select. It returns a 32-bit result, a flag that is high when that result is all zeros, and an overflow flag that the exception logic uses to trap.

It covers add and subtract in trapping and non-trapping forms, the four bitwise functions, constant and register-count shifts in three flavours, and placing an immediate in the upper half of a word. It also prepares the immediate: arithmetic-immediate forms sign-extend it, bitwise-immediate forms zero-extend it. Only the signed add, signed subtract and signed add-immediate may raise the overflow flag. Every other operation leaves it low.

A small control decoder turns the operation select into a struct of strobes. A datapath with one shared adder, one logic unit and one barrel shifter acts on those strobes.

Top module: `int_alu`

## Requirements
- R1: Operations ADD (0), SUB (2) and ADDI (4) return opA+opB, opA-opB and opA+sign-extended imm16, modulo 2^32. The overflow flag is high exactly when the true signed result falls outside the 32-bit two's-complement range.
- R2: Operations ADDU (1), SUBU (3) and ADDIU (5) return the same wrapped sums as their trapping counterparts. They never raise the overflow flag.
- R3: Bitwise operations, shift operations and LUI (codes 6 to 19) never raise the overflow flag.
- R4: ADDI (4) and ADDIU (5) sign-extend imm16, copying imm16 bit 15 into result bits 31:16 of the addend, and do not use opB.
- R5: ANDI (10), ORI (11) and XORI (12) zero-extend imm16 and combine it with opA. AND (6), OR (7), XOR (8) and NOR (9) combine opA with opB.
- R6: LUI (19) returns imm16 in bits 31:16 and zeros in bits 15:0.
- R7: SLL (13) and SRL (14) shift opB left or right by shamt and fill vacated bits with zeros.
- R8: SRA (15) and SRAV (18) shift opB right and fill vacated bits with a copy of opB bit 31.
- R9: SLLV (16), SRLV (17) and SRAV (18) shift opB by opA bits 4:0. Bits 31:5 of opA have no effect.
- R10: The zero flag is high exactly when the 32-bit result is zero.
- R11: Operation codes 20 to 31 return a zero result with the overflow flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First register operand; its low 5 bits are the count for the variable shifts |
| opB | input | 32 | Second register operand; the value shifted by the shift operations |
| imm16 | input | 16 | Instruction immediate |
| shamt | input | 5 | Constant shift count taken from the instruction |
| opSel | input | 5 | Operation select, encodings as listed in the requirements |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is zero |
| overflow | output | 1 | Signed overflow trap request |

## Verification
The bench builds the unit with its default 32-bit data width and 16-bit immediate, because the overflow boundaries at 0x7FFFFFFF and 0x80000000 only mean anything at the real width. At that width every one of the 32 shift counts can be swept for both the constant and the register-count forms, and the register count is driven with random upper bits so the masking to bits 4:0 is tested. For each of the 32 operation codes, including the undefined ones, a grid of boundary operands and a pseudo-random stream are applied. Every result is compared against 64-bit signed arithmetic computed in the bench.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_ADDI  = 5'd4,
    OP_ADDIU = 5'd5,
    OP_AND   = 5'd6,
    OP_OR    = 5'd7,
    OP_XOR   = 5'd8,
    OP_NOR   = 5'd9,
    OP_ANDI  = 5'd10,
    OP_ORI   = 5'd11,
    OP_XORI  = 5'd12,
    OP_SLL   = 5'd13,
    OP_SRL   = 5'd14,
    OP_SRA   = 5'd15,
    OP_SLLV  = 5'd16,
    OP_SRLV  = 5'd17,
    OP_SRAV  = 5'd18,
    OP_LUI   = 5'd19
  } aluOp_e;

  typedef enum logic [2:0] {
    U_NONE,
    U_ARITH,
    U_LOGIC,
    U_SHIFT,
    U_UPPER
  } unit_e;

  typedef enum logic [1:0] {
    LF_AND,
    LF_OR,
    LF_XOR,
    LF_NOR
  } logicFn_e;

  typedef struct packed {
    unit_e    unit;
    logic     useImm;
    logic     immSigned;
    logic     subtract;
    logic     trapEn;
    logicFn_e logicFn;
    logic     shLeft;
    logic     shArith;
    logic     shVar;
  } aluStrobe_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobe_t      strobe
);

  always_comb begin
    strobe = '{unit: U_NONE, useImm: 1'b0, immSigned: 1'b0, subtract: 1'b0,
               trapEn: 1'b0, logicFn: LF_AND, shLeft: 1'b0, shArith: 1'b0,
               shVar: 1'b0};
    case (opSel)
      OP_ADD:   begin strobe.unit = U_ARITH; strobe.trapEn = 1'b1; end
      OP_ADDU:  begin strobe.unit = U_ARITH; end
      OP_SUB:   begin strobe.unit = U_ARITH; strobe.subtract = 1'b1; strobe.trapEn = 1'b1; end
      OP_SUBU:  begin strobe.unit = U_ARITH; strobe.subtract = 1'b1; end
      OP_ADDI:  begin
        strobe.unit = U_ARITH; strobe.useImm = 1'b1;
        strobe.immSigned = 1'b1; strobe.trapEn = 1'b1;
      end
      OP_ADDIU: begin
        strobe.unit = U_ARITH; strobe.useImm = 1'b1; strobe.immSigned = 1'b1;
      end
      OP_AND:   begin strobe.unit = U_LOGIC; strobe.logicFn = LF_AND; end
      OP_OR:    begin strobe.unit = U_LOGIC; strobe.logicFn = LF_OR;  end
      OP_XOR:   begin strobe.unit = U_LOGIC; strobe.logicFn = LF_XOR; end
      OP_NOR:   begin strobe.unit = U_LOGIC; strobe.logicFn = LF_NOR; end
      OP_ANDI:  begin strobe.unit = U_LOGIC; strobe.logicFn = LF_AND; strobe.useImm = 1'b1; end
      OP_ORI:   begin strobe.unit = U_LOGIC; strobe.logicFn = LF_OR;  strobe.useImm = 1'b1; end
      OP_XORI:  begin strobe.unit = U_LOGIC; strobe.logicFn = LF_XOR; strobe.useImm = 1'b1; end
      OP_SLL:   begin strobe.unit = U_SHIFT; strobe.shLeft = 1'b1; end
      OP_SRL:   begin strobe.unit = U_SHIFT; end
      OP_SRA:   begin strobe.unit = U_SHIFT; strobe.shArith = 1'b1; end
      OP_SLLV:  begin strobe.unit = U_SHIFT; strobe.shLeft = 1'b1; strobe.shVar = 1'b1; end
      OP_SRLV:  begin strobe.unit = U_SHIFT; strobe.shVar = 1'b1; end
      OP_SRAV:  begin strobe.unit = U_SHIFT; strobe.shArith = 1'b1; strobe.shVar = 1'b1; end
      OP_LUI:   begin strobe.unit = U_UPPER; end
      default:  ;
    endcase
  end

endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter #(
  parameter  int DATA_W  = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  value,
  input  logic [SHAMT_W-1:0] amount,
  input  logic               shLeft,
  input  logic               shArith,
  output logic [DATA_W-1:0]  shifted
);

  function automatic logic [DATA_W-1:0] bitRev(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [DATA_W-1:0] stage [SHAMT_W+1];
  logic              fillBit;

  // Left shifts run through the right shifter on bit-reversed data.
  assign stage[0] = shLeft ? bitRev(value) : value;
  assign fillBit  = shArith & ~shLeft & value[DATA_W-1];

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amount[k]
      ? {{STEP{fillBit}}, stage[k][DATA_W-1:STEP]}
      : stage[k];
  end

  assign shifted = shLeft ? bitRev(stage[SHAMT_W]) : stage[SHAMT_W];

  // R8
  always_comb begin
    if (shArith && !shLeft)
      sra_sign_chk: assert (shifted[DATA_W-1] == value[DATA_W-1])
        else $error("arithmetic right shift lost the sign bit");
  end

  // R7
  always_comb begin
    if (shLeft)
      sll_low_chk: assert ((shifted & ~({DATA_W{1'b1}} << amount)) == '0)
        else $error("left shift did not zero-fill the low bits");
  end

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter  int DATA_W  = 32,
  parameter  int IMM_W   = 16,
  localparam int SHAMT_W = $clog2(DATA_W),
  localparam int EXT_W   = DATA_W - IMM_W
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [IMM_W-1:0]   imm16,
  input  logic [SHAMT_W-1:0] shamt,
  input  aluStrobe_t         strobe,
  output logic [DATA_W-1:0]  result,
  output logic               zero,
  output logic               overflow
);

  logic [DATA_W-1:0]  immExt;
  logic [DATA_W-1:0]  srcB;
  logic [DATA_W-1:0]  addB;
  logic [DATA_W-1:0]  sum;
  logic [DATA_W-1:0]  logicRes;
  logic [DATA_W-1:0]  shiftRes;
  logic [DATA_W-1:0]  upperRes;
  logic [SHAMT_W-1:0] shCount;
  logic               rawOvf;

  // Immediate preparation: sign or zero extension chosen by the strobe.
  assign immExt = {{EXT_W{strobe.immSigned & imm16[IMM_W-1]}}, imm16};
  assign srcB   = strobe.useImm ? immExt : opB;

  // Shared adder; subtraction inverts B and injects the carry.
  assign addB   = strobe.subtract ? ~srcB : srcB;
  assign sum    = opA + addB + DATA_W'(strobe.subtract);
  assign rawOvf = (opA[DATA_W-1] == addB[DATA_W-1]) && (sum[DATA_W-1] != opA[DATA_W-1]);

  always_comb begin
    case (strobe.logicFn)
      LF_AND:  logicRes = opA & srcB;
      LF_OR:   logicRes = opA | srcB;
      LF_XOR:  logicRes = opA ^ srcB;
      default: logicRes = ~(opA | srcB);
    endcase
  end

  assign shCount = strobe.shVar ? opA[SHAMT_W-1:0] : shamt;

  int_alu_shifter #(.DATA_W(DATA_W)) u_shifter (
    .value   (opB),
    .amount  (shCount),
    .shLeft  (strobe.shLeft),
    .shArith (strobe.shArith),
    .shifted (shiftRes)
  );

  assign upperRes = {imm16, {EXT_W{1'b0}}};

  always_comb begin
    case (strobe.unit)
      U_ARITH: result = sum;
      U_LOGIC: result = logicRes;
      U_SHIFT: result = shiftRes;
      U_UPPER: result = upperRes;
      default: result = '0;
    endcase
  end

  assign overflow = strobe.trapEn & rawOvf;
  assign zero     = (result == '0);

  // R6
  always_comb begin
    if (strobe.unit == U_UPPER)
      lui_low_chk: assert (result[EXT_W-1:0] == '0 && result[DATA_W-1:EXT_W] == imm16)
        else $error("upper-immediate result malformed");
  end

  // R5
  always_comb begin
    if (strobe.unit == U_LOGIC && strobe.useImm && strobe.logicFn == LF_AND)
      andi_upper_chk: assert (result[DATA_W-1:IMM_W] == '0)
        else $error("bitwise immediate was not zero-extended");
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter  int DATA_W  = 32,
  parameter  int IMM_W   = 16,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [IMM_W-1:0]   imm16,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [OP_W-1:0]    opSel,
  output logic [DATA_W-1:0]  result,
  output logic               zero,
  output logic               overflow
);

  aluStrobe_t strobe;

  int_alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  int_alu_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_datapath (
    .opA      (opA),
    .opB      (opB),
    .imm16    (imm16),
    .shamt    (shamt),
    .strobe   (strobe),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  // R2 R3 R11
  always_comb begin
    if (opSel != OP_ADD && opSel != OP_SUB && opSel != OP_ADDI)
      no_overflow_chk: assert (!overflow)
        else $error("overflow raised by a non-trapping operation");
  end

  // R11
  always_comb begin
    if (opSel > OP_LUI)
      undef_zero_chk: assert (result == '0 && zero)
        else $error("undefined operation produced a result");
  end

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opA, opB;
  logic [15:0] imm16;
  logic [4:0]  shamt;
  logic [4:0]  opSel;
  logic [31:0] result;
  logic        zero, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  int_alu u_int_alu (
    .opA(opA), .opB(opB), .imm16(imm16), .shamt(shamt), .opSel(opSel),
    .result(result), .zero(zero), .overflow(overflow)
  );

  function automatic string tagOf(input int op);
    case (op)
      0, 2, 4:        return "R1";
      1, 3:           return "R2";
      5:              return "R4";
      6, 7, 8, 9:     return "R3";
      10, 11, 12:     return "R5";
      13, 14:         return "R7";
      15:             return "R8";
      16, 17, 18:     return "R9";
      19:             return "R6";
      default:        return "R11";
    endcase
  endfunction

  function automatic void model(input int op, input logic [31:0] a, input logic [31:0] b,
                                input logic [15:0] imm, input logic [4:0] sh,
                                output logic [31:0] r, output logic ov);
    longint sa, sb, si, full;
    logic [31:0] sext, zext;
    sext = {{16{imm[15]}}, imm};
    zext = {16'h0000, imm};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    si = longint'($signed(sext));
    full = 0;
    ov = 1'b0;
    r  = 32'h0;
    case (op)
      0, 1: begin full = sa + sb; r = a + b; end
      2, 3: begin full = sa - sb; r = a - b; end
      4, 5: begin full = sa + si; r = a + sext; end
      6:  r = a & b;
      7:  r = a | b;
      8:  r = a ^ b;
      9:  r = ~(a | b);
      10: r = a & zext;
      11: r = a | zext;
      12: r = a ^ zext;
      13: r = b << sh;
      14: r = b >> sh;
      15: r = 32'($signed(b) >>> sh);
      16: r = b << a[4:0];
      17: r = b >> a[4:0];
      18: r = 32'($signed(b) >>> a[4:0]);
      19: r = {imm, 16'h0000};
      default: r = 32'h0;
    endcase
    if (op == 0 || op == 2 || op == 4)
      ov = (full > 64'sd2147483647) || (full < -64'sd2147483648);
  endfunction

  task automatic apply(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, input logic [4:0] sh);
    logic [31:0] expR;
    logic        expOv;
    @(negedge clk);
    opSel = op[4:0]; opA = a; opB = b; imm16 = imm; shamt = sh;
    #1;
    model(op, a, b, imm, sh, expR, expOv);
    checks++;
    if (result !== expR) begin
      errors++;
      $display("FAIL %s result op=%0d a=%h b=%h imm=%h sh=%0d: actual %h expected %h",
               tagOf(op), op, a, b, imm, sh, result, expR);
    end
    checks++;
    if (overflow !== expOv) begin
      errors++;
      $display("FAIL %s overflow op=%0d a=%h b=%h imm=%h: actual %b expected %b (R3 if not 0/2/4)",
               tagOf(op), op, a, b, imm, overflow, expOv);
    end
    checks++;
    if (zero !== (expR == 32'h0)) begin
      errors++;
      $display("FAIL R10 zero op=%0d: actual %b expected %b", op, zero, expR == 32'h0);
    end
  endtask

  logic [31:0] corners [8] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000,
                               32'hffffffff, 32'hfffffffe, 32'h12345678, 32'ha5a5a5a5};
  logic [15:0] immCorners [6] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
  logic [31:0] lfsr = 32'hace1_2468;

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    opA = '0; opB = '0; imm16 = '0; shamt = '0; opSel = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10: idle state with all-zero inputs gives zero result and zero flag
    apply(0, 32'h0, 32'h0, 16'h0, 5'd0);
    // R1 R2: exact overflow boundaries
    apply(0, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
    apply(1, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
    apply(2, 32'h80000000, 32'h1, 16'h0, 5'd0);
    apply(3, 32'h80000000, 32'h1, 16'h0, 5'd0);
    apply(4, 32'h7fffffff, 32'h1, 16'h0001, 5'd0);
    apply(4, 32'h80000000, 32'h0, 16'hffff, 5'd0);
    // R10: subtract equal operands gives zero
    apply(2, 32'h12345678, 32'h12345678, 16'h0, 5'd0);
    for (int op = 0; op < 32; op++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(op, corners[i], corners[j], corners[j][15:0], corners[j][4:0]);
      for (int i = 0; i < 8; i++)
        for (int k = 0; k < 6; k++)
          apply(op, corners[i], 32'h0f0f0f0f, immCorners[k], 5'(k));
      for (int n = 0; n < 60; n++) begin
        logic [31:0] ra, rb;
        lfsr = nextRand(lfsr); ra = lfsr;
        lfsr = nextRand(lfsr); rb = lfsr;
        apply(op, ra, rb, rb[31:16], ra[9:5]);
      end
    end
    // R7 R8 R9: every shift count, constant and register forms; upper opA bits randomised
    for (int s = 0; s < 32; s++) begin
      for (int v = 0; v < 3; v++) begin
        logic [31:0] val;
        val = (v == 0) ? 32'h80000001 : (v == 1) ? 32'h7ffffffe : 32'hc3a5_5a3c;
        lfsr = nextRand(lfsr);
        for (int op = 13; op <= 18; op++)
          apply(op, {lfsr[31:5], 5'(s)}, val, 16'h0, 5'(s));
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule